// File: doc/BRIEF.md
# ADC channel sequencing controller

This controller sits between the configuration of an analog-to-digital converter and its sample/hold front end. For every channel it selects the analog input feeding up to four sample/hold channels (CH0 to CH3) and decides when each channel is put into hold. It also decides the order in which the held values go to a single shared converter. Each acquisition ends on a trigger strobe, which may come from a software bit, a timer time-out or an external event. The controller then issues one convert-start pulse per held channel. Each pulse carries a 2-bit channel tag, and the next conversion waits for the converter's done handshake.

Four configuration controls shape a sequence:
- the channel count (1, 2 or 4);
- sequential or simultaneous sampling;
- whether successive sequences alternate between two input sets, called MUX A and MUX B;
- whether CH0 on the MUX A set scans through the inputs marked in a 16-bit bitmap.

An end-of-interrupt pulse sends the scan back to its start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `conv_start` and `sh_hold` are 0. With scan and alternate off, `ch_sel` equals `cfg_mux_a`. Field k of the select buses (bits [4k+3:4k]) belongs to CHk.
- R2: `cfg_chans` sets the channel count: 00 gives CH0 only, 01 gives CH0 and CH1, and 10 or 11 gives CH0 to CH3. No conversion is ever tagged with a channel outside that set.
- R3: With simultaneous sampling off, each accepted trigger holds exactly one channel. The next channel in turn is CH0 after a completed sequence. That trigger gives exactly one conversion, tagged with that channel. A sequence is complete after one trigger per channel.
- R4: With simultaneous sampling on, one trigger holds all selected channels together (`sh_hold` bit k = CHk). The channels are then converted in the order CH0, CH1, CH2, CH3, and each `conv_start` waits for the previous `conv_done`.
- R5: With a count of one channel, the simultaneous-sampling flag makes no difference: one conversion, tag 0, hold mask 0001.
- R6: With alternate off, every select field comes from `cfg_mux_a`. With alternate on, the first sequence uses `cfg_mux_a`. After that, each completed sequence switches between `cfg_mux_b` and `cfg_mux_a`.
- R7: With scan on, the CH0 select on a MUX A sequence is the set bit of `cfg_scan_map` at or above the scan pointer with the lowest index. When no set bit lies above, it wraps to the lowest set bit. Each completed MUX A sequence moves the pointer one position past the input it used. MUX B sequences use `cfg_mux_b` for CH0 and leave the pointer where it is. CH1 to CH3 are not affected by scan.
- R8: An `eoi` pulse returns the scan to the lowest set bit of `cfg_scan_map`.
- R9: With scan on and `cfg_scan_map` all zeros, CH0 selects input 0 on MUX A sequences, and no error is raised.
- R10: A trigger that arrives while `busy` is 1 is ignored. It starts no conversion and does not move the sequential channel order forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chans | input | 2 | Channel count: 00=1, 01=2, 1x=4 |
| cfg_simul | input | 1 | Simultaneous sampling enable |
| cfg_alt | input | 1 | Alternate MUX A/B on successive sequences |
| cfg_scan | input | 1 | CH0 scan enable (MUX A only) |
| cfg_scan_map | input | NIN | Inputs included in the CH0 scan |
| cfg_mux_a | input | 4*SELW | MUX A input select, field k for CHk |
| cfg_mux_b | input | 4*SELW | MUX B input select, field k for CHk |
| trig | input | 1 | Acquisition-end / conversion trigger strobe |
| conv_done | input | 1 | Converter finished the current conversion |
| eoi | input | 1 | End-of-interrupt pulse, restarts the scan |
| ch_sel | output | 4*SELW | Input currently selected for each channel |
| sh_hold | output | 4 | Per-channel hold enable, bit k = CHk |
| conv_start | output | 1 | One-cycle convert-start strobe |
| conv_tag | output | 2 | Channel being converted |
| busy | output | 1 | A trigger's conversions are in progress |

## Verification
A table of trigger runs covers every channel count in both sampling modes. For each run it checks the number of conversions, the order of their tags and the hold mask. This separates one channel per trigger from all channels per trigger, and shows that the simultaneous flag does nothing with a single channel. The directed runs start with alternate mode, which shows that MUX B is reached only on every second sequence. A sparse three-bit scan map follows. It shows ascending order, the wrap, the restart on `eoi`, and that MUX B sequences do not advance the pointer. The last runs use an empty map and a trigger during a slow conversion, which separate the fallback to input 0 and the dropping of an early trigger from normal sequencing.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NIN = 16,
  localparam int SELW = $clog2(NIN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_chans,
  input  logic                cfg_simul,
  input  logic                cfg_alt,
  input  logic                cfg_scan,
  input  logic [NIN-1:0]      cfg_scan_map,
  input  logic [4*SELW-1:0]   cfg_mux_a,
  input  logic [4*SELW-1:0]   cfg_mux_b,
  input  logic                trig,
  input  logic                conv_done,
  input  logic                eoi,
  output logic [4*SELW-1:0]   ch_sel,
  output logic [3:0]          sh_hold,
  output logic                conv_start,
  output logic [1:0]          conv_tag,
  output logic                busy
);

  logic [1:0]      slot;
  logic            phase;
  logic [SELW-1:0] scan_ptr;
  logic [SELW-1:0] scan_in;
  logic [SELW-1:0] scan_nxt;
  logic            use_b;
  logic            simul_eff;
  logic [1:0]      last;
  logic [1:0]      slot_eff;
  logic [3:0]      mask_all;

  assign last      = (cfg_chans == 2'b00) ? 2'd0 : (cfg_chans == 2'b01) ? 2'd1 : 2'd3;
  assign mask_all  = (last == 2'd0) ? 4'b0001 : (last == 2'd1) ? 4'b0011 : 4'b1111;
  assign simul_eff = cfg_simul && (last != 2'd0);
  assign slot_eff  = (slot > last) ? 2'd0 : slot;
  assign use_b     = cfg_alt && phase;

  always_comb begin
    logic            hit_up, hit_any;
    logic [SELW-1:0] idx_up, idx_any;
    hit_up  = 1'b0;
    hit_any = 1'b0;
    idx_up  = '0;
    idx_any = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      if (cfg_scan_map[i]) begin
        hit_any = 1'b1;
        idx_any = SELW'(i);
        if (i >= int'(scan_ptr)) begin
          hit_up = 1'b1;
          idx_up = SELW'(i);
        end
      end
    end
    scan_in = hit_up ? idx_up : (hit_any ? idx_any : '0);
  end

  assign scan_nxt = (scan_in == SELW'(NIN - 1)) ? '0 : scan_in + 1'b1;

  for (genvar k = 0; k < 4; k++) begin : g_sel
    if (k == 0) begin : g_ch0
      assign ch_sel[SELW-1:0] = use_b ? cfg_mux_b[SELW-1:0]
                              : (cfg_scan ? scan_in : cfg_mux_a[SELW-1:0]);
    end else begin : g_chn
      assign ch_sel[k*SELW +: SELW] = use_b ? cfg_mux_b[k*SELW +: SELW]
                                            : cfg_mux_a[k*SELW +: SELW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_tag   <= 2'd0;
      sh_hold    <= 4'b0;
      slot       <= 2'd0;
      phase      <= 1'b0;
      scan_ptr   <= '0;
    end else begin
      conv_start <= 1'b0;
      if (!cfg_alt) phase <= 1'b0;
      if (!busy) begin
        if (trig) begin
          busy       <= 1'b1;
          conv_start <= 1'b1;
          if (simul_eff) begin
            conv_tag <= 2'd0;
            sh_hold  <= mask_all;
          end else begin
            conv_tag <= slot_eff;
            sh_hold  <= 4'b0001 << slot_eff;
          end
        end
      end else if (conv_done && !conv_start) begin
        if (simul_eff && conv_tag < last) begin
          conv_tag   <= conv_tag + 2'd1;
          conv_start <= 1'b1;
        end else begin
          busy    <= 1'b0;
          sh_hold <= 4'b0;
          if (simul_eff || slot_eff >= last) begin
            slot <= 2'd0;
            if (cfg_alt) phase <= ~phase;
            if (cfg_scan && !use_b) scan_ptr <= scan_nxt;
          end else begin
            slot <= slot_eff + 2'd1;
          end
        end
      end
      if (eoi) scan_ptr <= '0;
    end
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sh_hold == 4'b0 && !conv_start));

  p_tag_in_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_tag <= last));

  p_tag_is_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> sh_hold[conv_tag]);

  p_start_waits_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_alt_off_mux_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_alt && !cfg_scan) |-> (ch_sel == cfg_mux_a));

  p_busy_trig_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> ($stable(sh_hold) && busy));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int NIN = 16;
  localparam int SELW = $clog2(NIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_chans = 2'b00;
  logic cfg_simul = 1'b0, cfg_alt = 1'b0, cfg_scan = 1'b0;
  logic [NIN-1:0] cfg_scan_map = '0;
  logic [4*SELW-1:0] cfg_mux_a = {4'd4, 4'd3, 4'd2, 4'd5};
  logic [4*SELW-1:0] cfg_mux_b = {4'd12, 4'd11, 4'd10, 4'd9};
  logic trig = 1'b0, conv_done = 1'b0, eoi = 1'b0;
  logic [4*SELW-1:0] ch_sel;
  logic [3:0] sh_hold;
  logic conv_start;
  logic [1:0] conv_tag;
  logic busy;

  adc_seq_ctrl #(.NIN(NIN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cfg_simul(cfg_simul),
    .cfg_alt(cfg_alt), .cfg_scan(cfg_scan), .cfg_scan_map(cfg_scan_map),
    .cfg_mux_a(cfg_mux_a), .cfg_mux_b(cfg_mux_b), .trig(trig),
    .conv_done(conv_done), .eoi(eoi), .ch_sel(ch_sel), .sh_hold(sh_hold),
    .conv_start(conv_start), .conv_tag(conv_tag), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int lat = 3;
  int cnt = 0;
  int nconv = 0;
  logic [1:0] tag_log [0:7];
  logic [3:0] hold_first;

  // converter model: done pulse a fixed number of cycles after each start
  always @(negedge clk) begin
    if (cnt != 0) begin
      cnt = cnt - 1;
      conv_done = (cnt == 0);
    end else conv_done = 1'b0;
    if (conv_start) cnt = lat;
  end

  always @(negedge clk) begin
    if (conv_start) begin
      if (nconv < 8) tag_log[nconv] = conv_tag;
      if (nconv == 0) hold_first = sh_hold;
      nconv = nconv + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk) eoi = 1'b1;
    @(negedge clk) eoi = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && busy; n++) @(negedge clk);
  endtask

  task automatic run_seq();
    nconv = 0;
    pulse_trig();
    wait_idle();
  endtask

  function automatic int ch0();
    return int'(ch_sel[SELW-1:0]);
  endfunction

  // {chans[1:0], simul, nconv[2:0], first tag[1:0], hold[3:0]}
  localparam logic [11:0] VEC [0:10] = '{
    12'b00_0_001_00_0001,
    12'b00_1_001_00_0001,
    12'b01_1_010_00_0011,
    12'b10_1_100_00_1111,
    12'b01_0_001_00_0001,
    12'b01_0_001_01_0010,
    12'b11_0_001_00_0001,
    12'b11_0_001_01_0010,
    12'b11_0_001_10_0100,
    12'b11_0_001_11_1000,
    12'b11_1_100_00_1111
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !conv_start, "R1 idle after reset", int'(busy), 0);
    check(sh_hold == 4'b0, "R1 hold released", int'(sh_hold), 0);
    check(ch_sel == cfg_mux_a, "R1 selects MUX A", int'(ch_sel), int'(cfg_mux_a));

    for (int v = 0; v < 11; v++) begin
      string req;
      cfg_chans = VEC[v][11:10];
      cfg_simul = VEC[v][9];
      req = (v == 1) ? "R5" : (VEC[v][9] ? "R4" : "R3");
      run_seq();
      check(nconv == int'(VEC[v][8:6]), {req, " R2 conversion count"}, nconv, int'(VEC[v][8:6]));
      check(hold_first == VEC[v][3:0], {req, " hold mask"}, int'(hold_first), int'(VEC[v][3:0]));
      for (int t = 0; t < nconv && t < 8; t++)
        check(tag_log[t] == VEC[v][5:4] + 2'(t), {req, " tag order"},
              int'(tag_log[t]), int'(VEC[v][5:4]) + t);
    end

    // R6 alternate sets
    cfg_chans = 2'b10; cfg_simul = 1'b1; cfg_alt = 1'b1;
    @(negedge clk);
    check(ch_sel == cfg_mux_a, "R6 first sequence MUX A", int'(ch_sel), int'(cfg_mux_a));
    run_seq();
    check(ch_sel == cfg_mux_b, "R6 second sequence MUX B", int'(ch_sel), int'(cfg_mux_b));
    run_seq();
    check(ch_sel == cfg_mux_a, "R6 third sequence MUX A", int'(ch_sel), int'(cfg_mux_a));
    cfg_alt = 1'b0;
    run_seq();
    check(ch_sel == cfg_mux_a, "R6 alternate off stays MUX A", int'(ch_sel), int'(cfg_mux_a));

    // R7 / R8 scan over inputs 7, 10, 13
    cfg_chans = 2'b00; cfg_simul = 1'b0; cfg_scan = 1'b1; cfg_scan_map = 16'h2480;
    pulse_eoi();
    check(ch0() == 7, "R8 restart at lowest", ch0(), 7);
    check(ch_sel[2*SELW-1:SELW] == 4'd2, "R7 CH1 unaffected", int'(ch_sel[2*SELW-1:SELW]), 2);
    run_seq();
    check(ch0() == 10, "R7 step ascending", ch0(), 10);
    run_seq();
    check(ch0() == 13, "R7 step ascending", ch0(), 13);
    run_seq();
    check(ch0() == 7, "R7 wrap to lowest", ch0(), 7);
    run_seq();
    check(ch0() == 10, "R7 step after wrap", ch0(), 10);
    pulse_eoi();
    check(ch0() == 7, "R8 eoi restarts scan", ch0(), 7);

    // R7 scan only on MUX A sequences
    cfg_alt = 1'b1;
    run_seq();
    check(ch0() == 9, "R7 MUX B ignores scan", ch0(), 9);
    run_seq();
    check(ch0() == 10, "R7 MUX B does not advance", ch0(), 10);
    cfg_alt = 1'b0;

    // R9 empty map
    cfg_scan_map = '0;
    @(negedge clk);
    check(ch0() == 0, "R9 empty map selects input 0", ch0(), 0);
    run_seq();
    check(ch0() == 0 && nconv == 1, "R9 empty map still converts", ch0(), 0);
    cfg_scan = 1'b0;

    // R10 trigger while busy
    lat = 8; cfg_chans = 2'b01; cfg_simul = 1'b0;
    nconv = 0;
    pulse_trig();
    @(negedge clk);
    pulse_trig();
    wait_idle();
    check(nconv == 1, "R10 busy trigger adds no conversion", nconv, 1);
    check(tag_log[0] == 2'd0, "R10 first tag", int'(tag_log[0]), 0);
    run_seq();
    check(nconv == 1 && tag_log[0] == 2'd1, "R10 order not advanced", int'(tag_log[0]), 1);
    check(!busy && sh_hold == 4'b0, "R1 idle after sequence", int'(sh_hold), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule